// File: doc/BRIEF.md
# Grouped Pin-Change Interrupt Controller

This block watches a 24-bit bank of general-purpose input pins, split into three groups of up to eight pins each. When an unmasked pin in a group toggles, in either direction, that group's sticky change flag is set. While the flag is set, the group's request line is driven high, provided the group is enabled and the processor's global interrupt enable is high. Group 0 takes pins 7..0 and group 2 takes pins 23..16. Group 1 takes pins 14..8 only, so pin 15 is never watched.

Each pin first passes through a two-stage synchroniser. A change is found by comparing the synchronised sample with the sample taken one cycle earlier. A flag clears when software writes a one to it, or when the processor acknowledges that group. If a new change and a clear fall in the same cycle, the change wins, so no event is lost.

Software reaches the controller through a byte-wide register port. The port has an address, a write strobe, write data and combinational read data. There is one group-enable register, one flag register, and one pin-mask register for each group.

Top module: `grp_toggle_irq`

## Requirements
- R1: After reset, every register reads 0x00 and all three request lines are low.
- R2: Address 0 holds the group enables. Bit g enables group g for g = 0, 1, 2. Bits 7..3 ignore writes and read zero.
- R3: Addresses 2, 3 and 4 hold the pin masks for groups 0, 1 and 2. In each mask, bit b enables pin 8*g+b. Bit 7 of the group 1 mask reads zero whatever is written. Addresses 5, 6 and 7 read 0x00.
- R4: A rising or falling change on an unmasked pin of group g sets bit g of the flag register at address 1. The bit is readable after the third rising clock edge that follows the pin change.
- R5: A change on a masked-off pin leaves the flags unchanged. A change on pin 15 never sets a flag.
- R6: A flag stays set until it is cleared. Writing a one to flag bit g clears it. Writing a zero leaves it unchanged.
- R7: A high level on ack_i[g] at a clock edge clears flag g.
- R8: irq_o[g] is high exactly when flag g, enable bit g and gie_i are all high.
- R9: If a flag-setting change is detected in the same cycle as a write-one clear or an acknowledge of that group, the flag ends up set.
- R10: A change in one group sets only that group's flag. Changes in several groups within one cycle set all of their flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 24 | Asynchronous input pins, three groups of eight |
| gie_i | input | 1 | Global interrupt enable from the processor |
| ack_i | input | 3 | Per-group acknowledge; clears the group's flag |
| reg_addr_i | input | 3 | Register address |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| irq_o | output | 3 | Per-group interrupt request |

## Verification
Single pins are toggled in both directions. This shows that the edge detector is polarity-blind and that its latency is exactly three edges. Masked pins, and the pinless bit 15, are toggled to show that the mask gates detection, not only the request. Changes are placed in one group, and then in two groups within the same cycle, to confirm that each change lands in its own flag and in no other. A change is also timed to coincide with a write-one clear and an acknowledge, which separates set-priority from clear-priority. The global enable and the group enables are then swept while a flag is held set, to isolate the request gating.

// File: rtl/gti_pkg.sv
package gti_pkg;
  localparam int NGRP  = 3;
  localparam int GW    = 8;
  localparam int NPINS = NGRP * GW;

  localparam logic [2:0] A_EN    = 3'd0;
  localparam logic [2:0] A_FLAG  = 3'd1;
  localparam logic [2:0] A_MASK0 = 3'd2;

  // Pins that physically exist in group g (group 1 lacks its top pin).
  function automatic logic [GW-1:0] pin_valid(input int g);
    return (g == 1) ? 8'h7F : 8'hFF;
  endfunction

  // Any unmasked bit that differs between two consecutive samples.
  function automatic logic any_change(input logic [GW-1:0] now_s,
                                      input logic [GW-1:0] old_s,
                                      input logic [GW-1:0] msk);
    return |((now_s ^ old_s) & msk);
  endfunction
endpackage

// File: rtl/gti_sync.sv
module gti_sync #(
  parameter int W      = 24,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] q_prev
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= '0;
    else        chain[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[i] <= '0;
      else        chain[i] <= chain[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_prev <= '0;
    else        q_prev <= chain[STAGES-1];
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gti_group.sv
module gti_group
  import gti_pkg::*;
#(
  parameter logic [GW-1:0] VALID = 8'hFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [GW-1:0] cur_i,
  input  logic [GW-1:0] prev_i,
  input  logic          mask_we_i,
  input  logic [GW-1:0] mask_wdata_i,
  input  logic          w1c_i,
  input  logic          ack_i,
  output logic [GW-1:0] mask_o,
  output logic          flag_o,
  output logic          hit_o
);
  logic clr;

  assign hit_o = any_change(cur_i, prev_i, mask_o);
  assign clr   = w1c_i | ack_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         mask_o <= '0;
    else if (mask_we_i) mask_o <= mask_wdata_i & VALID;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag_o <= 1'b0;
    else if (hit_o) flag_o <= 1'b1;
    else if (clr)   flag_o <= 1'b0;
  end

  AST_FLAG_SETS:   assert property (@(posedge clk) disable iff (!rst_n) hit_o |=> flag_o);                  // R4
  AST_W1C_CLEARS:  assert property (@(posedge clk) disable iff (!rst_n) (w1c_i && !hit_o) |=> !flag_o);     // R6
  AST_ACK_CLEARS:  assert property (@(posedge clk) disable iff (!rst_n) (ack_i && !hit_o) |=> !flag_o);     // R7
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (!hit_o && !clr) |=> $stable(flag_o)); // R6
  AST_SET_WINS:    assert property (@(posedge clk) disable iff (!rst_n) (hit_o && clr) |=> flag_o);         // R9
  AST_NOPIN_IDLE:  assert property (@(posedge clk) disable iff (!rst_n) ((cur_i ^ prev_i) & VALID) == '0 |-> !hit_o); // R5
endmodule

// File: rtl/grp_toggle_irq.sv
module grp_toggle_irq
  import gti_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_i,
  input  logic             gie_i,
  input  logic [NGRP-1:0]  ack_i,
  input  logic [2:0]       reg_addr_i,
  input  logic             reg_we_i,
  input  logic [7:0]       reg_wdata_i,
  output logic [7:0]       reg_rdata_o,
  output logic [NGRP-1:0]  irq_o
);
  logic [NPINS-1:0] pin_s, pin_p;
  logic [NGRP-1:0]  en_q, flag, hit, w1c, mask_we;
  logic [GW-1:0]    mask [NGRP];

  gti_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_i), .q(pin_s), .q_prev(pin_p)
  );

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    assign w1c[g]     = reg_we_i && (reg_addr_i == A_FLAG) && reg_wdata_i[g];
    assign mask_we[g] = reg_we_i && (reg_addr_i == A_MASK0 + 3'(g));

    gti_group #(.VALID(pin_valid(g))) u_grp (
      .clk(clk), .rst_n(rst_n),
      .cur_i(pin_s[g*GW +: GW]), .prev_i(pin_p[g*GW +: GW]),
      .mask_we_i(mask_we[g]), .mask_wdata_i(reg_wdata_i),
      .w1c_i(w1c[g]), .ack_i(ack_i[g]),
      .mask_o(mask[g]), .flag_o(flag[g]), .hit_o(hit[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                en_q <= '0;
    else if (reg_we_i && reg_addr_i == A_EN)   en_q <= reg_wdata_i[NGRP-1:0];
  end

  assign irq_o = flag & en_q & {NGRP{gie_i}};

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == A_EN)        reg_rdata_o[NGRP-1:0] = en_q;
    else if (reg_addr_i == A_FLAG) reg_rdata_o[NGRP-1:0] = flag;
    else begin
      for (int g = 0; g < NGRP; g++)
        if (reg_addr_i == A_MASK0 + 3'(g)) reg_rdata_o = mask[g];
    end
  end

  AST_IRQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n) !gie_i |-> irq_o == '0);          // R8
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n) (irq_o & ~flag) == '0);         // R8
  AST_EN_RSV_ZERO:   assert property (@(posedge clk) disable iff (!rst_n) (reg_addr_i == A_EN) |-> reg_rdata_o[7:NGRP] == '0); // R2
  AST_MASK1_TOP:     assert property (@(posedge clk) disable iff (!rst_n) mask[1][GW-1] == 1'b0);           // R3
endmodule

// File: tb/test_grp_toggle_irq.sv
`timescale 1ns/1ps
module test_grp_toggle_irq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] pin_i = '0;
  logic        gie_i = 1'b0;
  logic [2:0]  ack_i = '0;
  logic [2:0]  reg_addr_i = '0;
  logic        reg_we_i = 1'b0;
  logic [7:0]  reg_wdata_i = '0;
  logic [7:0]  reg_rdata_o;
  logic [2:0]  irq_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  typedef struct { string req; bit is_irq; logic [7:0] exp; } item_t;
  item_t q[$];

  always #2.5 clk = ~clk;

  grp_toggle_irq i_grp_toggle_irq (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .gie_i(gie_i), .ack_i(ack_i),
    .reg_addr_i(reg_addr_i), .reg_we_i(reg_we_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .irq_o(irq_o)
  );

  // Monitor: pops expected items and compares just after the falling edge.
  initial forever begin
    @(negedge clk);
    #1;
    while (q.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it  = q.pop_front();
      act = it.is_irq ? {5'b0, irq_o} : reg_rdata_o;
      n_chk++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: actual %02h expected %02h", it.req, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr_i = a; reg_wdata_i = d; reg_we_i = 1'b1;
    @(negedge clk);
    reg_we_i = 1'b0; reg_wdata_i = '0;
  endtask

  task automatic exp_reg(input logic [2:0] a, input logic [7:0] e, input string r);
    @(negedge clk);
    reg_addr_i = a;
    q.push_back('{req: r, is_irq: 1'b0, exp: e});
    #2;
  endtask

  task automatic exp_irq(input logic [2:0] e, input string r);
    @(negedge clk);
    q.push_back('{req: r, is_irq: 1'b1, exp: {5'b0, e}});
    #2;
  endtask

  task automatic toggle(input logic [23:0] pins);
    @(negedge clk);
    pin_i = pin_i ^ pins;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int a = 0; a < 5; a++) exp_reg(3'(a), 8'h00, "R1");
    exp_irq(3'b000, "R1");
    // R2 enable register, reserved bits
    wr(3'd0, 8'hFF);
    exp_reg(3'd0, 8'h07, "R2");
    // R3 masks and unmapped addresses
    wr(3'd2, 8'hFF); wr(3'd3, 8'hFF); wr(3'd4, 8'h0F);
    exp_reg(3'd2, 8'hFF, "R3");
    exp_reg(3'd3, 8'h7F, "R3");
    exp_reg(3'd4, 8'h0F, "R3");
    for (int a = 5; a < 8; a++) exp_reg(3'(a), 8'h00, "R3");
    gie_i = 1'b1;
    // R4 rising edge, exact latency
    @(negedge clk); pin_i[0] = 1'b1;
    repeat (2) @(negedge clk);
    q.push_back('{req: "R4 early", is_irq: 1'b0, exp: 8'h00}); reg_addr_i = 3'd1; #2;
    exp_reg(3'd1, 8'h01, "R4");
    exp_irq(3'b001, "R8");
    // R6 write zero keeps, write one clears
    wr(3'd1, 8'h00);
    exp_reg(3'd1, 8'h01, "R6");
    wr(3'd1, 8'h01);
    exp_reg(3'd1, 8'h00, "R6");
    // R4 falling edge, R7 acknowledge
    toggle(24'h000001);
    exp_reg(3'd1, 8'h01, "R4");
    @(negedge clk); ack_i = 3'b001;
    @(negedge clk); ack_i = 3'b000;
    exp_reg(3'd1, 8'h00, "R7");
    // R5 masked pin and pinless bit 15
    toggle(24'h100000);
    exp_reg(3'd1, 8'h00, "R5");
    toggle(24'h008000);
    exp_reg(3'd1, 8'h00, "R5");
    // R10 single group
    toggle(24'h020000);
    exp_reg(3'd1, 8'h04, "R10");
    exp_irq(3'b100, "R8");
    // R8 gating
    gie_i = 1'b0;
    exp_irq(3'b000, "R8");
    gie_i = 1'b1;
    wr(3'd0, 8'h03);
    exp_irq(3'b000, "R8");
    exp_reg(3'd1, 8'h04, "R8");
    wr(3'd0, 8'h07);
    wr(3'd1, 8'h04);
    // R9 set wins over clear
    toggle(24'h000200);
    exp_reg(3'd1, 8'h02, "R4");
    @(negedge clk); pin_i[10] = 1'b1;
    repeat (2) @(negedge clk);
    reg_addr_i = 3'd1; reg_wdata_i = 8'h02; reg_we_i = 1'b1; ack_i = 3'b010;
    @(negedge clk);
    reg_we_i = 1'b0; reg_wdata_i = '0; ack_i = '0;
    exp_reg(3'd1, 8'h02, "R9");
    wr(3'd1, 8'h02);
    exp_reg(3'd1, 8'h00, "R6");
    // R10 two groups in one cycle
    toggle(24'h040008);
    exp_reg(3'd1, 8'h05, "R10");
    exp_irq(3'b101, "R10");
    repeat (2) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule